// File: doc/BRIEF.md
# Instruction Cache with Sequential Prefetch Buffer

This block is a read-only instruction cache. It uses fully associative lookup, and each line holds two 32-bit words. Beside the cache sits a small, fully associative buffer for sequential prefetch. The CPU presents a byte fetch address and holds `fetch_valid` until `fetch_done` pulses with the instruction on `fetch_data`. The CPU must drop the request, or move to a new address, in the same cycle that it sees `fetch_done`.

Both structures are searched in the same cycle. A cache hit answers at once. A buffer hit answers one cycle later. If the fetch misses both, the buffer is emptied and the line is fetched from memory as a two-word burst into the block chosen by a round-robin pointer. The fetch is then answered. After that, the next `SB_DEPTH` sequential words are burst-read into the buffer. Memory requests are held until granted, and returned words arrive one per `mem_rd_valid` strobe. While a prefetch is running, a new fetch waits. When the prefetch finishes, the fetch is looked up afresh.

Top module: `icache_sbuf`

## Requirements
- R1: After reset, no line and no buffer entry is valid. `fetch_done` and `mem_rd_req` are low, and the first fetch to any address issues a memory request.
- R2: A cache hit raises `fetch_done` one cycle after the fetch is accepted and issues no memory request. Byte address bit 2 selects word 1 (set) or word 0 (clear) of the line.
- R3: A fetch that misses both structures issues one burst with `mem_rd_len` = 2 at the line base (fetch address with bits 2:0 cleared). The fetch is answered with the requested word after both words have arrived.
- R4: Once a line fill ends, one burst with `mem_rd_len` = `SB_DEPTH` is issued at the line base plus 8. The words it returns are then served from the buffer.
- R5: A fetch that misses the cache but hits the buffer raises `fetch_done` two cycles after acceptance, one cycle later than a cache hit, and issues no memory request.
- R6: After a double miss, words that the buffer held before it are no longer served from the buffer.
- R7: Line fills take blocks in round-robin order starting at block 0. After `LINES` further fills, the oldest line misses while younger lines still hit.
- R8: The replacement pointer moves only when a line fill completes. Cache hits and buffer hits leave the eviction order unchanged.
- R9: A fetch presented while a prefetch is running waits until the prefetch ends. It is then looked up again, and if its word was prefetched it is served from the buffer with no further memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch request, held until `fetch_done` |
| fetch_addr | input | ADDR_W | Fetch byte address; bits 1:0 ignored |
| fetch_done | output | 1 | One-cycle pulse: `fetch_data` is valid |
| fetch_data | output | 32 | Instruction word returned |
| mem_rd_req | output | 1 | Burst read request, held until granted |
| mem_rd_addr | output | ADDR_W | Burst start byte address, 8-byte aligned |
| mem_rd_len | output | LEN_W | Number of words in the burst |
| mem_rd_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rd_valid | input | 1 | A returned word is present |
| mem_rd_data | input | 32 | Returned word, in address order |

## Verification
The assertions assume that memory returns words only after it has granted a request, in address order, and never more words than were requested. They also assume that the CPU keeps `fetch_valid` high until `fetch_done`. The bench memory model grants a held request one cycle after it sees it. It then returns exactly the requested number of words, with an idle cycle between them, and it never strobes data outside a granted burst. The bench fetch task holds the request until it sees the response and lowers it in that same cycle. This keeps every response tied to a fetch that was high in the cycle before.

// File: rtl/icsb_pkg.sv
package icsb_pkg;

    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 2;
    localparam int LINE_BYTES = LINE_WORDS * (WORD_W / 8);

    typedef logic [WORD_W-1:0] word_t;

    // Controller sequencing
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SB_RESP,
        ST_FILL_REQ,
        ST_FILL_DATA,
        ST_PF_REQ,
        ST_PF_DATA
    } ic_state_e;

    // Result of a parallel associative search
    typedef struct packed {
        logic  hit;
        word_t data;
    } hit_rsp_t;

    // Round-robin step over n entries
    function automatic int unsigned rr_next(int unsigned cur, int unsigned n);
        return (cur == n - 1) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/icsb_line_store.sv
module icsb_line_store
    import icsb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINES  = 4,
    localparam int WA_W  = ADDR_W - 2,
    localparam int TAG_W = ADDR_W - 3,
    localparam int WAY_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WA_W-1:0]  lk_word_addr,
    output hit_rsp_t         lk_rsp,
    input  logic             wr_en,
    input  logic [WAY_W-1:0] wr_way,
    input  logic             wr_word,
    input  word_t            wr_data,
    input  logic             wr_commit,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [TAG_W-1:0] tag_q   [LINES];
    logic [LINES-1:0] valid_q;
    word_t            words_q [LINES][LINE_WORDS];
    logic [LINES-1:0] match;

    // One comparator per block
    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (tag_q[g] == lk_word_addr[WA_W-1:1]);
    end

    always_comb begin
        lk_rsp = '0;
        for (int i = 0; i < LINES; i++) begin
            if (match[i]) begin
                lk_rsp.hit  = 1'b1;
                lk_rsp.data = lk_rsp.data | words_q[i][lk_word_addr[0]];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                tag_q[i] <= '0;
                for (int w = 0; w < LINE_WORDS; w++) words_q[i][w] <= '0;
            end
        end else if (wr_en) begin
            words_q[wr_way][wr_word] <= wr_data;
            if (!wr_word) valid_q[wr_way] <= 1'b0;
            if (wr_commit) begin
                valid_q[wr_way] <= 1'b1;
                tag_q[wr_way]   <= wr_tag;
            end
        end
    end

endmodule

// File: rtl/icsb_prefetch_buf.sv
module icsb_prefetch_buf
    import icsb_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SB_DEPTH = 4,
    localparam int WA_W    = ADDR_W - 2,
    localparam int IDX_W   = $clog2(SB_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WA_W-1:0]  lk_word_addr,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output word_t            rd_data,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WA_W-1:0]  wr_tag,
    input  word_t            wr_data
);

    logic [WA_W-1:0]     tag_q  [SB_DEPTH];
    word_t               data_q [SB_DEPTH];
    logic [SB_DEPTH-1:0] valid_q;
    logic [SB_DEPTH-1:0] match;

    for (genvar g = 0; g < SB_DEPTH; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (tag_q[g] == lk_word_addr);
    end

    always_comb begin
        lk_hit = |match;
        lk_idx = '0;
        for (int i = SB_DEPTH - 1; i >= 0; i--) begin
            if (match[i]) lk_idx = IDX_W'(i);
        end
    end

    assign rd_data = data_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int i = 0; i < SB_DEPTH; i++) begin
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end
        end else if (flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            tag_q[wr_idx]   <= wr_tag;
            data_q[wr_idx]  <= wr_data;
        end
    end

endmodule

// File: rtl/icsb_ctrl.sv
module icsb_ctrl
    import icsb_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LINES    = 4,
    parameter int SB_DEPTH = 4,
    parameter int LEN_W    = 3,
    localparam int WA_W    = ADDR_W - 2,
    localparam int TAG_W   = ADDR_W - 3,
    localparam int WAY_W   = $clog2(LINES),
    localparam int IDX_W   = $clog2(SB_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_valid,
    input  logic [WA_W-1:0]  fetch_word_addr,
    output logic             fetch_done,
    output word_t            fetch_data,
    input  hit_rsp_t         c_rsp,
    input  logic             s_hit,
    input  logic [IDX_W-1:0] s_hit_idx,
    output logic [IDX_W-1:0] s_rd_idx,
    input  word_t            s_rd_data,
    output logic             lw_en,
    output logic [WAY_W-1:0] lw_way,
    output logic             lw_word,
    output word_t            lw_data,
    output logic             lw_commit,
    output logic [TAG_W-1:0] lw_tag,
    output logic             sb_flush,
    output logic             sb_wr_en,
    output logic [IDX_W-1:0] sb_wr_idx,
    output logic [WA_W-1:0]  sb_wr_tag,
    output word_t            sb_wr_data,
    output logic             mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic [LEN_W-1:0] mem_rd_len,
    input  logic             mem_rd_gnt,
    input  logic             mem_rd_valid,
    input  word_t            mem_rd_data
);

    ic_state_e        state_q;
    logic [WA_W-1:0]  req_q;
    logic [WAY_W-1:0] victim_q;
    logic [IDX_W-1:0] beat_q;
    word_t            word0_q;
    logic [IDX_W-1:0] sb_idx_q;
    logic             done_q;
    word_t            data_q;
    logic [WA_W-1:0]  line_base_w;
    logic [WA_W-1:0]  pf_base_w;

    assign line_base_w = {req_q[WA_W-1:1], 1'b0};
    assign pf_base_w   = line_base_w + WA_W'(LINE_WORDS);

    assign fetch_done = done_q;
    assign fetch_data = data_q;
    assign s_rd_idx   = sb_idx_q;

    // Double miss empties the buffer in the same cycle it is detected
    assign sb_flush = (state_q == ST_IDLE) && fetch_valid && !c_rsp.hit && !s_hit;

    assign lw_en     = (state_q == ST_FILL_DATA) && mem_rd_valid;
    assign lw_way    = victim_q;
    assign lw_word   = beat_q[0];
    assign lw_data   = mem_rd_data;
    assign lw_commit = lw_en && beat_q[0];
    assign lw_tag    = req_q[WA_W-1:1];

    assign sb_wr_en   = (state_q == ST_PF_DATA) && mem_rd_valid;
    assign sb_wr_idx  = beat_q;
    assign sb_wr_tag  = pf_base_w + WA_W'(beat_q);
    assign sb_wr_data = mem_rd_data;

    always_comb begin
        mem_rd_req  = 1'b0;
        mem_rd_addr = '0;
        mem_rd_len  = '0;
        if (state_q == ST_FILL_REQ) begin
            mem_rd_req  = 1'b1;
            mem_rd_addr = {line_base_w, 2'b00};
            mem_rd_len  = LEN_W'(LINE_WORDS);
        end else if (state_q == ST_PF_REQ) begin
            mem_rd_req  = 1'b1;
            mem_rd_addr = {pf_base_w, 2'b00};
            mem_rd_len  = LEN_W'(SB_DEPTH);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            req_q    <= '0;
            victim_q <= '0;
            beat_q   <= '0;
            word0_q  <= '0;
            sb_idx_q <= '0;
            done_q   <= 1'b0;
            data_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (fetch_valid) begin
                        if (c_rsp.hit) begin
                            done_q <= 1'b1;
                            data_q <= c_rsp.data;
                        end else if (s_hit) begin
                            sb_idx_q <= s_hit_idx;
                            state_q  <= ST_SB_RESP;
                        end else begin
                            req_q   <= fetch_word_addr;
                            state_q <= ST_FILL_REQ;
                        end
                    end
                end
                ST_SB_RESP: begin
                    done_q  <= 1'b1;
                    data_q  <= s_rd_data;
                    state_q <= ST_IDLE;
                end
                ST_FILL_REQ: begin
                    if (mem_rd_gnt) begin
                        beat_q  <= '0;
                        state_q <= ST_FILL_DATA;
                    end
                end
                ST_FILL_DATA: begin
                    if (mem_rd_valid) begin
                        beat_q <= beat_q + 1'b1;
                        if (!beat_q[0]) begin
                            word0_q <= mem_rd_data;
                        end else begin
                            done_q   <= 1'b1;
                            data_q   <= req_q[0] ? mem_rd_data : word0_q;
                            victim_q <= WAY_W'(rr_next(int'(victim_q), LINES));
                            state_q  <= ST_PF_REQ;
                        end
                    end
                end
                ST_PF_REQ: begin
                    if (mem_rd_gnt) begin
                        beat_q  <= '0;
                        state_q <= ST_PF_DATA;
                    end
                end
                ST_PF_DATA: begin
                    if (mem_rd_valid) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == IDX_W'(SB_DEPTH - 1)) state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/icache_sbuf.sv
module icache_sbuf
    import icsb_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LINES    = 4,
    parameter int SB_DEPTH = 4,
    localparam int LEN_W   = $clog2(SB_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_done,
    output logic [31:0]       fetch_data,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic [LEN_W-1:0]  mem_rd_len,
    input  logic              mem_rd_gnt,
    input  logic              mem_rd_valid,
    input  logic [31:0]       mem_rd_data
);

    localparam int WA_W  = ADDR_W - 2;
    localparam int TAG_W = ADDR_W - 3;
    localparam int WAY_W = $clog2(LINES);
    localparam int IDX_W = $clog2(SB_DEPTH);

    logic [WA_W-1:0]  word_addr;
    logic             byte_sel_unused;
    hit_rsp_t         c_rsp;
    logic             s_hit;
    logic [IDX_W-1:0] s_hit_idx;
    logic [IDX_W-1:0] s_rd_idx;
    word_t            s_rd_data;
    logic             lw_en;
    logic [WAY_W-1:0] lw_way;
    logic             lw_word;
    word_t            lw_data;
    logic             lw_commit;
    logic [TAG_W-1:0] lw_tag;
    logic             sb_flush;
    logic             sb_wr_en;
    logic [IDX_W-1:0] sb_wr_idx;
    logic [WA_W-1:0]  sb_wr_tag;
    word_t            sb_wr_data;

    assign word_addr       = fetch_addr[ADDR_W-1:2];
    assign byte_sel_unused = ^fetch_addr[1:0];

    icsb_line_store #(.ADDR_W(ADDR_W), .LINES(LINES)) u_lines (
        .clk(clk), .rst(rst),
        .lk_word_addr(word_addr), .lk_rsp(c_rsp),
        .wr_en(lw_en), .wr_way(lw_way), .wr_word(lw_word),
        .wr_data(lw_data), .wr_commit(lw_commit), .wr_tag(lw_tag)
    );

    icsb_prefetch_buf #(.ADDR_W(ADDR_W), .SB_DEPTH(SB_DEPTH)) u_pbuf (
        .clk(clk), .rst(rst),
        .lk_word_addr(word_addr), .lk_hit(s_hit), .lk_idx(s_hit_idx),
        .rd_idx(s_rd_idx), .rd_data(s_rd_data),
        .flush(sb_flush), .wr_en(sb_wr_en), .wr_idx(sb_wr_idx),
        .wr_tag(sb_wr_tag), .wr_data(sb_wr_data)
    );

    icsb_ctrl #(.ADDR_W(ADDR_W), .LINES(LINES), .SB_DEPTH(SB_DEPTH), .LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .fetch_valid(fetch_valid), .fetch_word_addr(word_addr),
        .fetch_done(fetch_done), .fetch_data(fetch_data),
        .c_rsp(c_rsp), .s_hit(s_hit), .s_hit_idx(s_hit_idx),
        .s_rd_idx(s_rd_idx), .s_rd_data(s_rd_data),
        .lw_en(lw_en), .lw_way(lw_way), .lw_word(lw_word),
        .lw_data(lw_data), .lw_commit(lw_commit), .lw_tag(lw_tag),
        .sb_flush(sb_flush), .sb_wr_en(sb_wr_en), .sb_wr_idx(sb_wr_idx),
        .sb_wr_tag(sb_wr_tag), .sb_wr_data(sb_wr_data),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_len(mem_rd_len),
        .mem_rd_gnt(mem_rd_gnt), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

endmodule

// File: rtl/icsb_checker.sv
module icsb_checker #(
    parameter int ADDR_W   = 32,
    parameter int SB_DEPTH = 4,
    parameter int LEN_W    = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              fetch_valid,
    input logic              fetch_done,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic [LEN_W-1:0]  mem_rd_len,
    input logic              mem_rd_gnt
);

    // R1: the cycle after reset is quiet on both sides
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!fetch_done && !mem_rd_req));

    // R2: every response answers a fetch that was pending the cycle before
    a_r2_done_follows_fetch: assert property (@(posedge clk) disable iff (rst)
        fetch_done |-> $past(fetch_valid));

    // R3: a line fill burst starts on a line boundary
    a_r3_fill_aligned: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && mem_rd_len == LEN_W'(2)) |-> (mem_rd_addr[2:0] == 3'b000));

    // R3: an ungranted request stays put
    a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_gnt) |=>
            (mem_rd_req && $stable(mem_rd_addr) && $stable(mem_rd_len)));

    // R4: any other burst is a full, aligned prefetch
    a_r4_pf_shape: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && mem_rd_len != LEN_W'(2)) |->
            (mem_rd_len == LEN_W'(SB_DEPTH) && mem_rd_addr[2:0] == 3'b000));

endmodule

bind icache_sbuf icsb_checker #(
    .ADDR_W(ADDR_W), .SB_DEPTH(SB_DEPTH), .LEN_W(LEN_W)
) u_chk (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_done(fetch_done),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_len(mem_rd_len), .mem_rd_gnt(mem_rd_gnt)
);

// File: tb/tb_icache_sbuf.sv
module tb_icache_sbuf;

    localparam int ADDR_W   = 32;
    localparam int LINES    = 4;
    localparam int SB_DEPTH = 4;
    localparam int LEN_W    = $clog2(SB_DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              fetch_valid = 1'b0;
    logic [ADDR_W-1:0] fetch_addr = '0;
    logic              fetch_done;
    logic [31:0]       fetch_data;
    logic              mem_rd_req;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [LEN_W-1:0]  mem_rd_len;
    logic              mem_rd_gnt = 1'b0;
    logic              mem_rd_valid = 1'b0;
    logic [31:0]       mem_rd_data = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int n_req = 0;
    logic [31:0] log_addr [64];
    int          log_len  [64];

    always #2 clk = ~clk;

    icache_sbuf #(.ADDR_W(ADDR_W), .LINES(LINES), .SB_DEPTH(SB_DEPTH)) dut (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_done(fetch_done), .fetch_data(fetch_data),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_len(mem_rd_len),
        .mem_rd_gnt(mem_rd_gnt), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    function automatic logic [31:0] memw(logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'hC0DE_0000;
    endfunction

    // Memory model: grant one cycle after a request, then one word every other cycle
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && mem_rd_req) begin
                logic [31:0] base;
                int          len;
                base = mem_rd_addr;
                len  = int'(mem_rd_len);
                if (n_req < 64) begin
                    log_addr[n_req] = base;
                    log_len[n_req]  = len;
                end
                n_req++;
                mem_rd_gnt = 1'b1;
                @(negedge clk);
                mem_rd_gnt = 1'b0;
                for (int k = 0; k < len; k++) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = memw(base + 32'(4 * k));
                    @(negedge clk);
                    mem_rd_valid = 1'b0;
                    @(negedge clk);
                end
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fetch(logic [31:0] a, output logic [31:0] d, output int cyc);
        fetch_valid = 1'b1;
        fetch_addr  = a;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!fetch_done && cyc < 500);
        d = fetch_data;
        fetch_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (30) @(negedge clk);
    endtask

    // Expect a line fill for address a; returns with the response seen
    task automatic miss_check(string req, logic [31:0] a);
        logic [31:0] d;
        int          c;
        int          r0;
        r0 = n_req;
        fetch(a, d, c);
        chk({req, " miss data"}, d, memw(a));
        chk({req, " fill request issued"}, 32'(n_req - r0 >= 1), 32'd1);
        chk({req, " fill addr"}, log_addr[r0], {a[31:3], 3'b000});
        chk({req, " fill len"}, 32'(log_len[r0]), 32'd2);
    endtask

    task automatic hit_check(string req, logic [31:0] a, int exp_cyc);
        logic [31:0] d;
        int          c;
        int          r0;
        r0 = n_req;
        fetch(a, d, c);
        chk({req, " data"}, d, memw(a));
        chk({req, " latency"}, 32'(c), 32'(exp_cyc));
        chk({req, " no memory request"}, 32'(n_req - r0), 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 done low after reset", 32'(fetch_done), 32'd0);
        chk("R1 no request after reset", 32'(mem_rd_req), 32'd0);
        // R1: cold cache, even word -> way 0
        miss_check("R1", 32'h0000_0100);
        settle();
    endtask

    task automatic t_fill_and_prefetch();
        // R3: odd word of a line; R4: prefetch shape follows
        miss_check("R3", 32'h0000_1004);
        settle();
        chk("R4 prefetch addr", log_addr[n_req - 1], 32'h0000_1008);
        chk("R4 prefetch len", 32'(log_len[n_req - 1]), 32'(SB_DEPTH));
    endtask

    task automatic t_cache_hit();
        hit_check("R2 word0", 32'h0000_1000, 1);
        hit_check("R2 word1", 32'h0000_1004, 1);
    endtask

    task automatic t_buffer_hit();
        hit_check("R5 entry2", 32'h0000_1010, 2);
        hit_check("R5 entry3", 32'h0000_1014, 2);
        hit_check("R4 entry0", 32'h0000_1008, 2);
    endtask

    task automatic t_flush();
        // Double miss at 0x1018 (way 2) replaces buffer contents
        miss_check("R6 setup", 32'h0000_1018);
        settle();
        // R6: 0x1010 was buffered before; now must go to memory (way 3)
        miss_check("R6", 32'h0000_1010);
        settle();
    endtask

    task automatic t_fifo();
        // R7: cache now holds 0x100(w0) 0x1000(w1) 0x1018(w2) 0x1010(w3)
        miss_check("R7 evict oldest", 32'h0000_8004);
        settle();
        // R8: earlier hits did not move the pointer, so 0x1000 survives
        hit_check("R8 younger line kept", 32'h0000_1000, 1);
        miss_check("R7 oldest line gone", 32'h0000_0100);
        settle();
        hit_check("R7 line kept", 32'h0000_1018, 1);
        miss_check("R7 next victim", 32'h0000_1000);
        settle();
    endtask

    task automatic t_wait_prefetch();
        logic [31:0] d;
        int          c;
        int          r0;
        r0 = n_req;
        fetch(32'h0000_2000, d, c);
        chk("R9 miss data", d, memw(32'h0000_2000));
        // Next fetch issued immediately, while prefetch is still running
        fetch(32'h0000_200C, d, c);
        chk("R9 data after wait", d, memw(32'h0000_200C));
        chk("R9 only fill and prefetch requested", 32'(n_req - r0), 32'd2);
        chk("R9 waited for prefetch", 32'(c > 2), 32'd1);
        settle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill_and_prefetch();
        t_cache_hit();
        t_buffer_hit();
        t_flush();
        t_fifo();
        t_wait_prefetch();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule